// File: doc/BRIEF.md
# Universal Shift Register

This block is a parameterised storage word (four bits by default) whose contents are rewritten on each rising clock edge according to a two-bit operation code. It can keep its value, move every bit one place toward the top, move every bit one place toward the bottom, or take a whole new word from a parallel input. When moving toward the bottom, a separate control chooses between filling the vacated top bit from a serial input (logical) or repeating the old top bit (arithmetic, sign preserving).

Every bit is one slice of a repeated cell array. Each slice has a four-way selector that feeds its flop from its own output, the bit above it, the bit below it, or its parallel input. The end slices take their outer neighbours from the serial inputs or from the sign fill. The full register value is the only output. Reset is synchronous and active low.

Top module: `usr_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, every bit of `q` becomes 0 after that edge, whatever the other inputs are.
- R2: Operation code 2'b00 (hold) leaves `q` unchanged across the edge.
- R3: Operation code 2'b01 (toward MSB) gives, after the edge, q[i] = old q[i-1] for i >= 1.
- R4: In operation code 2'b01, bit 0 after the edge equals `ser_lo` sampled at that edge.
- R5: Operation code 2'b10 (toward LSB) gives, after the edge, q[i] = old q[i+1] for i < WIDTH-1.
- R6: In operation code 2'b10 with `arith` = 0, the MSB after the edge equals `ser_hi` sampled at that edge.
- R7: In operation code 2'b10 with `arith` = 1, the MSB after the edge equals the old MSB, and `ser_hi` is ignored.
- R8: Operation code 2'b11 (load) makes `q` equal to `pdata` after the edge.
- R9: `q` changes only at rising clock edges; the result of an operation code is visible from the edge where it is sampled until the next edge.
- R10: Outside operation code 2'b10 the `arith` and `ser_hi` inputs have no effect, and `ser_lo` is used only in operation code 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 2 | 00 hold, 01 toward MSB, 10 toward LSB, 11 load |
| arith | input | 1 | 1 selects arithmetic fill for moves toward LSB |
| ser_lo | input | 1 | Serial bit entering bit 0 in moves toward MSB |
| ser_hi | input | 1 | Serial bit entering the MSB in logical moves toward LSB |
| pdata | input | WIDTH | Parallel load word |
| q | output | WIDTH | Register contents |

## Verification
The hardest case is arithmetic fill after several moves toward the LSB. It has to come from a negative value, with `ser_hi` held opposite to the sign so that a wrong fill source shows up. The bench loads 4'b1001, then shifts right with `arith` = 1 and `ser_hi` = 0 several times in a row, and expects 1100, 1110 and then 1111. It then repeats the moves with `arith` = 0 and `ser_hi` = 1 on a positive value, so each fill source is the only one that gives the expected word. Ignore behaviour is checked by driving the unused serial and select inputs to their opposite values during hold, load and move toward MSB, and comparing `q` after each edge.

// File: rtl/usr_pkg.sv
// Package: shared operation encoding for the universal shift register.
// Assumes: the two-bit code values are fixed by the interface.
package usr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_UP    = 2'b01,
        OP_DOWN  = 2'b10,
        OP_LOAD  = 2'b11
    } usr_op_e;
endpackage

// File: rtl/usr_edge_fill.sv
// Module: usr_edge_fill
// Works out the outer neighbour values seen by the two end slices.
// Assumes: the old MSB is taken from the registered output.
module usr_edge_fill (
    input  logic arith,
    input  logic ser_hi,
    input  logic old_msb,
    output logic top_fill
);
    // Choose between the serial input and sign repetition for the top slice.
    always_comb begin
        top_fill = arith ? old_msb : ser_hi;
    end
endmodule

// File: rtl/usr_slice.sv
// Module: usr_slice
// One bit of the register: a four-way selector in front of a single flop.
// Assumes: neighbour inputs already include the edge fill values.
module usr_slice
    import usr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  usr_op_e op,
    input  logic    from_below,
    input  logic    from_above,
    input  logic    par_in,
    output logic    bit_q
);
    logic nxt;

    // Select the next bit value according to the operation code.
    always_comb begin
        unique case (op)
            OP_HOLD: nxt = bit_q;
            OP_UP:   nxt = from_below;
            OP_DOWN: nxt = from_above;
            OP_LOAD: nxt = par_in;
            default: nxt = bit_q;
        endcase
    end

    // Store the selected value; a low reset clears the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= nxt;
    end
endmodule

// File: rtl/usr_top.sv
// Module: usr_top
// Universal shift register: hold, move toward MSB, move toward LSB, or
// parallel load, with a logical or arithmetic fill for moves toward LSB.
// Assumes: single clock domain, synchronous active-low reset.
module usr_top
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op,
    input  logic             arith,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] pdata,
    output logic [WIDTH-1:0] q
);
    localparam int MSB = WIDTH - 1;

    usr_op_e    op_e;
    logic       top_fill;
    logic [WIDTH+1:0] ext;   // ext[0] = ser_lo, ext[WIDTH+1] = top fill

    // Map the raw code onto the shared enumeration.
    always_comb begin
        op_e = usr_op_e'(op);
    end

    usr_edge_fill u_fill (
        .arith    (arith),
        .ser_hi   (ser_hi),
        .old_msb  (q[MSB]),
        .top_fill (top_fill)
    );

    // Build the extended neighbour vector around the stored word.
    always_comb begin
        ext = {top_fill, q, ser_lo};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        usr_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .op         (op_e),
            .from_below (ext[i]),
            .from_above (ext[i+2]),
            .par_in     (pdata[i]),
            .bit_q      (q[i])
        );
    end
endmodule

// File: rtl/usr_checker.sv
// Module: usr_checker
// Property checks on the universal shift register, bound to usr_top.
// Assumes: reset is synchronous and active low.
module usr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op,
    input logic             arith,
    input logic             ser_lo,
    input logic             ser_hi,
    input logic [WIDTH-1:0] pdata,
    input logic [WIDTH-1:0] q
);
    logic seen;
    // Mark that at least one edge has passed, so that $past is meaningful.
    always_ff @(posedge clk) seen <= 1'b1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        seen && !rst_n |=> q == '0); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b00 |=> $stable(q)); // R2
    AST_UP_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b01 |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0])); // R3
    AST_UP_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b01 |=> q[0] == $past(ser_lo)); // R4
    AST_DOWN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b10 |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1])); // R5
    AST_DOWN_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b10 && !arith |=> q[WIDTH-1] == $past(ser_hi)); // R6
    AST_DOWN_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b10 && arith |=> $stable(q[WIDTH-1])); // R7
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b11 |=> q == $past(pdata)); // R8
endmodule

bind usr_top usr_checker #(.WIDTH(WIDTH)) u_usr_checker (
    .clk(clk), .rst_n(rst_n), .op(op), .arith(arith),
    .ser_lo(ser_lo), .ser_hi(ser_hi), .pdata(pdata), .q(q)
);

// File: tb/usr_top_bench.sv
// Directed bench for usr_top: one task per scenario, each checking itself.
module usr_top_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op = 2'b00;
    logic         arith = 1'b0;
    logic         ser_lo = 1'b0;
    logic         ser_hi = 1'b0;
    logic [W-1:0] pdata = '0;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;

    usr_top #(.WIDTH(W)) u_usr_top (
        .clk(clk), .rst_n(rst_n), .op(op), .arith(arith),
        .ser_lo(ser_lo), .ser_hi(ser_hi), .pdata(pdata), .q(q)
    );

    // 200 MHz clock: 5 ns period.
    always #2.5 clk = ~clk;

    // Compare q with an expected word and report.
    task automatic expect_q(input logic [W-1:0] exp, input string req);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected=%b", req, q, exp);
        end
    endtask

    // Apply inputs at the falling edge, pass one rising edge, sample after it.
    task automatic step(input logic [1:0] o, input logic a, input logic sl,
                        input logic sh, input logic [W-1:0] pd);
        @(negedge clk);
        op = o; arith = a; ser_lo = sl; ser_hi = sh; pdata = pd;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        step(2'b11, 1'b1, 1'b1, 1'b1, 4'b1111);
        expect_q(4'b0000, "R1 reset overrides load");
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_load_hold();
        step(2'b11, 1'b1, 1'b1, 1'b1, 4'b1010);
        expect_q(4'b1010, "R8 load");
        step(2'b00, 1'b1, 1'b1, 1'b1, 4'b0101);
        expect_q(4'b1010, "R2 hold, R10 ignores other inputs");
        step(2'b11, 1'b0, 1'b0, 1'b0, 4'b0110);
        expect_q(4'b0110, "R8 second load");
        // Change the inputs between edges; q should not move (R9).
        @(negedge clk); op = 2'b11; pdata = 4'b1111;
        #1;
        expect_q(4'b0110, "R9 no change before edge");
        @(posedge clk); #1;
        expect_q(4'b1111, "R9 change at edge");
    endtask

    task automatic t_left();
        step(2'b11, 1'b0, 1'b0, 1'b0, 4'b0101);
        step(2'b01, 1'b1, 1'b1, 1'b0, 4'b0000);
        expect_q(4'b1011, "R3 R4 up with ser_lo=1");
        step(2'b01, 1'b0, 1'b0, 1'b1, 4'b1111);
        expect_q(4'b0110, "R3 R4 up with ser_lo=0, R10");
    endtask

    task automatic t_right_logic();
        step(2'b11, 1'b0, 1'b0, 1'b0, 4'b0110);
        step(2'b10, 1'b0, 1'b0, 1'b1, 4'b0000);
        expect_q(4'b1011, "R5 R6 logical fill 1");
        step(2'b10, 1'b0, 1'b1, 1'b0, 4'b0000);
        expect_q(4'b0101, "R5 R6 logical fill 0");
    endtask

    task automatic t_right_arith();
        step(2'b11, 1'b0, 1'b0, 1'b0, 4'b1001);
        step(2'b10, 1'b1, 1'b0, 1'b0, 4'b0000);
        expect_q(4'b1100, "R7 arithmetic 1");
        step(2'b10, 1'b1, 1'b0, 1'b0, 4'b0000);
        expect_q(4'b1110, "R7 arithmetic 2");
        step(2'b10, 1'b1, 1'b0, 1'b0, 4'b0000);
        expect_q(4'b1111, "R7 arithmetic 3");
        step(2'b11, 1'b0, 1'b0, 1'b0, 4'b0110);
        step(2'b10, 1'b1, 1'b0, 1'b1, 4'b0000);
        expect_q(4'b0011, "R7 positive keeps 0, ser_hi ignored");
    endtask

    initial begin
        // Watchdog: a hung run counts as a failure and still reports.
        fork
            begin
                #100000;
                errors++; checks++;
                $display("FAIL watchdog: q=%b expected=done", q);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none
        @(posedge clk); #1;
        expect_q(4'b0000, "R1 reset state");
        t_reset();
        t_load_hold();
        t_left();
        t_right_logic();
        t_right_arith();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule